// File: doc/BRIEF.md
# Priority Window Overlay and Blanking Mixer

This block is the final pixel stage of an on-screen character display. On every pixel clock it receives the character cell being drawn (row and column), the glyph pixel, the outline pixel and the two colour-select bits of that cell. It returns a 3-bit RGB value, a fast-blank strobe and a half-tone strobe. The fast-blank strobe tells the downstream video switch to replace the host picture. The half-tone strobe tells it to dim the host picture behind a translucent window.

Four rectangular background windows are held in twelve byte registers, which a simple write port loads. Each window has a cell-row range, a cell-column range, an enable, an RGB colour and an extended-colour bit. When windows overlap, the lowest-numbered window is in front. Character colours are taken from an eight-entry palette supplied by the row control logic. The extended-colour bit of the front window covering a cell moves that cell's character colour into the upper half of the palette. Outputs are registered, with one cycle of latency.

Top module: `osd_window_mixer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rgb_o`, `fblank_o` and `htone_o` are 0. Reset clears all twelve window bytes, so every window is disabled.
- R2: A write with `wr_en`=1 stores `wr_data` in byte `wr_addr`, where window n (0..3) owns addresses 3n, 3n+1 and 3n+2. Byte 3n: row start in [7:4], row end in [3:0]. Byte 3n+1: column start in [7:3], enable in [2], extended-colour in [1]. Byte 3n+2: column end in [7:3], RGB in [2:0] (bit 2 red, bit 1 green, bit 0 blue). Writes to addresses 12..15 are ignored.
- R3: A window covers a cell only when its enable is 1, row start ≤ row end, column start ≤ column end, and the cell lies inside both inclusive ranges. A window whose start is greater than its end covers nothing.
- R4: Where windows overlap, window 0 has the highest priority, then 1, then 2, with window 3 the lowest. The front window alone provides the window colour and the extended-colour bit.
- R5: A glyph pixel outside any extended window shows palette entry `csel_i` (0..3). Entry k is `pal_i[3k+2:3k]`.
- R6: If the front window covering the cell has its extended-colour bit set, a glyph pixel shows palette entry 4+`csel_i`.
- R7: An outline pixel (`border_px_i`=1) outputs RGB 000 and takes precedence over glyph and window.
- R8: A glyph pixel takes precedence over window colour. Where neither glyph nor outline is present, a covered cell shows the front window's RGB. An uncovered cell shows 000.
- R9: `htone_o` is 1 exactly when the display is enabled, the cell is covered by a window, and neither glyph nor outline is present.
- R10: With the display enabled, `fblank_o` is 1 over glyph or outline pixels. With `fb_chars_only_i`=0 it is also 1 over covered cells; with `fb_chars_only_i`=1 windows do not raise it.
- R11: `force_blank_i`=1 drives `fblank_o` to 1 whatever the other inputs are.
- R12: With `osd_en_i`=0, `rgb_o` and `htone_o` are 0 and `fblank_o` equals `force_blank_i`.
- R13: Every output reflects the inputs present at the previous rising clock edge and the window bytes held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Window byte write strobe |
| wr_addr | input | 4 | Window byte address |
| wr_data | input | 8 | Window byte value |
| pal_i | input | 24 | Eight 3-bit palette entries, entry k at bits 3k+2..3k |
| osd_en_i | input | 1 | Global display enable |
| force_blank_i | input | 1 | Hold fast-blank high |
| fb_chars_only_i | input | 1 | 1: fast-blank over characters only |
| row_i | input | 4 | Current cell row |
| col_i | input | 5 | Current cell column |
| glyph_px_i | input | 1 | Glyph pixel |
| border_px_i | input | 1 | Outline pixel |
| csel_i | input | 2 | Cell colour select |
| rgb_o | output | 3 | Pixel colour, bit 2 red |
| fblank_o | output | 1 | Fast-blank strobe |
| htone_o | output | 1 | Half-tone strobe |

## Verification
Every pixel result is due exactly one rising edge after its inputs are presented. A window byte write affects pixels only from the edge after the write. The bench drives inputs on the falling edge and compares the outputs at the next falling edge, half a period after the edge that registered them. During write cycles it drives no pixel and makes no comparison, so a new window byte and a pixel sample never share an edge.

// File: rtl/osdmix_pkg.sv
package osdmix_pkg;
    localparam int NWIN   = 4;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 5;
    localparam int RGB_W  = 3;
    localparam int NPAL   = 8;
    localparam int NBYTES = NWIN * 3;
    localparam int ADDR_W = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [ROW_W-1:0] row_s;
        logic [ROW_W-1:0] row_e;
        logic [COL_W-1:0] col_s;
        logic [COL_W-1:0] col_e;
        logic             en;
        logic             ext;
        logic [RGB_W-1:0] rgb;
    } window_t;

    typedef struct packed {
        logic             any;
        logic             ext;
        logic [RGB_W-1:0] rgb;
    } win_pick_t;

    function automatic window_t unpack_win(input logic [7:0] b0,
                                           input logic [7:0] b1,
                                           input logic [7:0] b2);
        window_t w;
        w.row_s = b0[7:4];
        w.row_e = b0[3:0];
        w.col_s = b1[7:3];
        w.en    = b1[2];
        w.ext   = b1[1];
        w.col_e = b2[7:3];
        w.rgb   = b2[2:0];
        return w;
    endfunction

    function automatic logic covers(input window_t w,
                                    input logic [ROW_W-1:0] r,
                                    input logic [COL_W-1:0] c);
        return w.en && (w.row_s <= w.row_e) && (w.col_s <= w.col_e) &&
               (r >= w.row_s) && (r <= w.row_e) &&
               (c >= w.col_s) && (c <= w.col_e);
    endfunction
endpackage

// File: rtl/osdmix_win_regs.sv
module osdmix_win_regs
    import osdmix_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output window_t [NWIN-1:0]     win_o
);
    logic [NBYTES-1:0][7:0] bytes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
        end else if (wr_en && (int'(wr_addr) < NBYTES)) begin
            bytes_q[wr_addr] <= wr_data;
        end
    end

    for (genvar n = 0; n < NWIN; n++) begin : g_unpack
        assign win_o[n] = unpack_win(bytes_q[3*n], bytes_q[3*n+1], bytes_q[3*n+2]);
    end
endmodule

// File: rtl/osdmix_win_hit.sv
module osdmix_win_hit
    import osdmix_pkg::*;
(
    input  window_t [NWIN-1:0] win_i,
    input  logic [ROW_W-1:0]   row_i,
    input  logic [COL_W-1:0]   col_i,
    output logic [NWIN-1:0]    hit_o
);
    for (genvar n = 0; n < NWIN; n++) begin : g_hit
        assign hit_o[n] = covers(win_i[n], row_i, col_i);
    end
endmodule

// File: rtl/osdmix_prio.sv
module osdmix_prio
    import osdmix_pkg::*;
(
    input  window_t [NWIN-1:0] win_i,
    input  logic [NWIN-1:0]    hit_i,
    output win_pick_t          pick_o
);
    always_comb begin
        pick_o = '0;
        for (int n = NWIN - 1; n >= 0; n--) begin
            if (hit_i[n]) begin
                pick_o.any = 1'b1;
                pick_o.ext = win_i[n].ext;
                pick_o.rgb = win_i[n].rgb;
            end
        end
    end
endmodule

// File: rtl/osd_window_mixer.sv
module osd_window_mixer
    import osdmix_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [NPAL*RGB_W-1:0]  pal_i,
    input  logic                   osd_en_i,
    input  logic                   force_blank_i,
    input  logic                   fb_chars_only_i,
    input  logic [ROW_W-1:0]       row_i,
    input  logic [COL_W-1:0]       col_i,
    input  logic                   glyph_px_i,
    input  logic                   border_px_i,
    input  logic [1:0]             csel_i,
    output logic [RGB_W-1:0]       rgb_o,
    output logic                   fblank_o,
    output logic                   htone_o
);
    window_t [NWIN-1:0] win;
    logic [NWIN-1:0]    hit;
    win_pick_t          pick;

    osdmix_win_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_o(win)
    );
    osdmix_win_hit u_hit (
        .win_i(win), .row_i(row_i), .col_i(col_i), .hit_o(hit)
    );
    osdmix_prio u_prio (
        .win_i(win), .hit_i(hit), .pick_o(pick)
    );

    logic [2:0]       pal_idx;
    logic [RGB_W-1:0] glyph_rgb;
    logic [RGB_W-1:0] rgb_d;
    logic             fb_d, ht_d, char_px;

    assign pal_idx   = {pick.any & pick.ext, csel_i};
    assign glyph_rgb = pal_i[RGB_W*pal_idx +: RGB_W];
    assign char_px   = glyph_px_i | border_px_i;

    always_comb begin
        rgb_d = '0;
        ht_d  = 1'b0;
        fb_d  = force_blank_i;
        if (osd_en_i) begin
            if (border_px_i)      rgb_d = '0;
            else if (glyph_px_i)  rgb_d = glyph_rgb;
            else if (pick.any)    rgb_d = pick.rgb;
            ht_d = pick.any & ~char_px;
            fb_d = force_blank_i | char_px | (pick.any & ~fb_chars_only_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_o    <= '0;
            fblank_o <= 1'b0;
            htone_o  <= 1'b0;
        end else begin
            rgb_o    <= rgb_d;
            fblank_o <= fb_d;
            htone_o  <= ht_d;
        end
    end
endmodule

// File: rtl/osdmix_checker.sv
module osdmix_checker
    import osdmix_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             osd_en_i,
    input logic             force_blank_i,
    input logic             glyph_px_i,
    input logic             border_px_i,
    input logic [RGB_W-1:0] rgb_o,
    input logic             fblank_o,
    input logic             htone_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (rgb_o == '0 && !fblank_o && !htone_o));

    // R7
    border_black_chk: assert property (@(posedge clk) disable iff (rst)
        (osd_en_i && border_px_i) |=> (rgb_o == '0 && fblank_o));

    // R9
    htone_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (glyph_px_i || border_px_i || !osd_en_i) |=> !htone_o);

    // R11
    force_blank_chk: assert property (@(posedge clk) disable iff (rst)
        force_blank_i |=> fblank_o);

    // R12
    osd_off_chk: assert property (@(posedge clk) disable iff (rst)
        !osd_en_i |=> (rgb_o == '0 && !htone_o && fblank_o == $past(force_blank_i)));
endmodule

bind osd_window_mixer osdmix_checker u_chk (
    .clk(clk), .rst(rst), .osd_en_i(osd_en_i), .force_blank_i(force_blank_i),
    .glyph_px_i(glyph_px_i), .border_px_i(border_px_i),
    .rgb_o(rgb_o), .fblank_o(fblank_o), .htone_o(htone_o)
);

// File: tb/sim_osd_window_mixer.sv
module sim_osd_window_mixer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [23:0] pal = 24'o76543210;
    logic osd_en = 1'b1, fblk = 1'b0, fbch = 1'b0;
    logic [3:0] row = '0;
    logic [4:0] col = '0;
    logic glyph = 1'b0, border = 1'b0;
    logic [1:0] csel = '0;
    logic [2:0] rgb;
    logic fb, ht;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] mb [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    osd_window_mixer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pal_i(pal), .osd_en_i(osd_en), .force_blank_i(fblk), .fb_chars_only_i(fbch),
        .row_i(row), .col_i(col), .glyph_px_i(glyph), .border_px_i(border),
        .csel_i(csel), .rgb_o(rgb), .fblank_o(fb), .htone_o(ht)
    );

    // Front window index covering (r,c), or -1
    function automatic int front(input logic [3:0] r, input logic [4:0] c);
        for (int n = 0; n < 4; n++) begin
            logic [3:0] rs, re; logic [4:0] cs, ce;
            rs = mb[3*n][7:4]; re = mb[3*n][3:0];
            cs = mb[3*n+1][7:3]; ce = mb[3*n+2][7:3];
            if (mb[3*n+1][2] && rs <= re && cs <= ce &&
                r >= rs && r <= re && c >= cs && c <= ce) return n;
        end
        return -1;
    endfunction

    function automatic logic [4:0] expect_out();
        int f; logic [2:0] e_rgb; logic e_fb, e_ht;
        f = front(row, col);
        e_rgb = 3'b000; e_ht = 1'b0; e_fb = fblk;
        if (osd_en) begin
            if (border) e_rgb = 3'b000;
            else if (glyph) e_rgb = pal[3*((f >= 0 && mb[3*f+1][1]) ? 4 + csel : csel) +: 3];
            else if (f >= 0) e_rgb = mb[3*f+2][2:0];
            e_ht = (f >= 0) && !glyph && !border;
            e_fb = fblk || glyph || border || (f >= 0 && !fbch);
        end
        return {e_rgb, e_fb, e_ht};
    endfunction

    task automatic check(input string req, input logic [4:0] exp);
        checks++;
        if ({rgb, fb, ht} !== exp) begin
            errors++;
            $display("FAIL %s: actual rgb=%b fb=%b ht=%b expected rgb=%b fb=%b ht=%b",
                     req, rgb, fb, ht, exp[4:2], exp[1], exp[0]);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 12) mb[a] = d;
    endtask

    task automatic px(input string req, input logic [3:0] r, input logic [4:0] c,
                      input logic g, input logic b, input logic [1:0] s);
        logic [4:0] e;
        row = r; col = c; glyph = g; border = b; csel = s;
        e = expect_out();
        @(negedge clk);
        check(req, e);
    endtask

    task automatic setwin(input int n, input logic [3:0] rs, input logic [3:0] re,
                          input logic [4:0] cs, input logic [4:0] ce,
                          input logic en, input logic ext, input logic [2:0] c);
        wr(3*n,   {rs, re});
        wr(3*n+1, {cs, en, ext, 1'b0});
        wr(3*n+2, {ce, c});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL R13: watchdog expired, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 12; i++) mb[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 5'b0);
        rst = 1'b0;
        @(negedge clk);
        // R1: windows cleared -> nothing covered
        px("R1 windows off after reset", 4'd2, 5'd3, 1'b0, 1'b0, 2'd0);

        // R2 R8: single window
        setwin(1, 4'd1, 4'd4, 5'd2, 5'd10, 1'b1, 1'b0, 3'b101);
        px("R2 R8 window colour", 4'd2, 5'd5, 1'b0, 1'b0, 2'd0);
        px("R3 edge inclusive", 4'd4, 5'd10, 1'b0, 1'b0, 2'd0);
        px("R3 outside col", 4'd4, 5'd11, 1'b0, 1'b0, 2'd0);
        px("R8 R5 glyph over window", 4'd2, 5'd5, 1'b1, 1'b0, 2'd2);
        px("R7 border black", 4'd2, 5'd5, 1'b1, 1'b1, 2'd3);
        // R4: window 0 overlaps with extended bit
        setwin(0, 4'd2, 4'd3, 5'd4, 5'd6, 1'b1, 1'b1, 3'b011);
        px("R4 front window", 4'd2, 5'd5, 1'b0, 1'b0, 2'd0);
        px("R6 extended bank", 4'd3, 5'd4, 1'b1, 1'b0, 2'd1);
        px("R4 rear window visible", 4'd1, 5'd5, 1'b0, 1'b0, 2'd0);
        // R3: start > end disables
        wr(0, {4'd5, 4'd3});
        px("R3 row start>end", 4'd2, 5'd5, 1'b0, 1'b0, 2'd0);
        // R2: ignored address
        wr(13, 8'hFF);
        px("R2 addr 13 ignored", 4'd12, 5'd30, 1'b0, 1'b0, 2'd0);
        // R10
        fbch = 1'b1;
        px("R10 chars only window", 4'd2, 5'd5, 1'b0, 1'b0, 2'd0);
        px("R10 chars only glyph", 4'd2, 5'd5, 1'b1, 1'b0, 2'd0);
        fbch = 1'b0;
        // R11
        fblk = 1'b1;
        px("R11 force blank", 4'd9, 5'd31, 1'b0, 1'b0, 2'd0);
        // R12
        osd_en = 1'b0;
        px("R12 off with force", 4'd2, 5'd5, 1'b1, 1'b0, 2'd1);
        fblk = 1'b0;
        px("R12 off", 4'd2, 5'd5, 1'b0, 1'b0, 2'd1);
        osd_en = 1'b1;

        // R13 random mix, one-cycle latency
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 15) == 0) wr($urandom_range(0, 11), 8'($urandom));
            if ($urandom_range(0, 31) == 0) pal = 24'($urandom);
            osd_en = ($urandom_range(0, 7) != 0);
            fblk   = ($urandom_range(0, 15) == 0);
            fbch   = 1'($urandom);
            px("R13 random R4 R6 R9", 4'($urandom_range(0, 15)), 5'($urandom),
               ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0), 2'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule